// File: doc/BRIEF.md
# Streaming Multiply-Accumulate-Round Unit

This block sits inside a datapath between two input queues and one output queue. The queue ports connect straight to the arithmetic, with no bus in between. In any cycle where both input queues report data and the internal pipeline can move, the unit pops one signed sample from each queue. It multiplies the two samples and adds the product to a wide running accumulator. It then rounds the sum, shifting it right by a configurable amount, and saturates it to the sample width. The rounded value goes to the output queue as soon as that queue has room.

The pipeline has two stages. The first stage registers the product. The second stage updates the accumulator and registers the rounded result. When the output queue is full, the result waits in the second stage and the first stage fills behind it. After that, no further samples are popped, so nothing is lost or repeated. Each operation captures the shift amount and a clear request at the moment its samples are popped. A clear request raised while no operation is accepted stays pending until the next operation takes it.

Top module: `mac_round_stream`

## Requirements
- R1: Both input queues are popped together (`a_pop` equals `b_pop` in every cycle), and only in a cycle where `a_nempty` and `b_nempty` are both high.
- R2: Each accepted operation adds the full signed product `a_data*b_data` to a 40-bit signed accumulator.
- R3: The pushed value is the updated accumulator plus 2^(s-1), arithmetically shifted right by s, where s is the 4-bit `cfg_shift` captured at the pop. No bias is added when s is 0.
- R4: The rounded value saturates to the signed 16-bit range [-32768, 32767].
- R5: `out_push` is high only while `out_full` is low. While a result waits on a full queue, `out_data` holds steady.
- R6: Every popped operation produces exactly one push, and results leave in pop order. Once the output queue blocks and both stages hold data, no further pops occur.
- R7: With a free output queue, the push for an operation popped in cycle c is visible in cycle c+2, and not in cycle c+1.
- R8: When `cfg_clear` is high in a cycle, the next accepted operation starts from a zero accumulator. A clear raised with no pop in that cycle stays pending until the next pop.
- R9: The shift and clear settings belong to the operation popped in the same cycle. Changing them later does not affect operations already in flight.
- R10: While reset is low there are no pops, and after reset there is no push until an operation has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| a_nempty | input | 1 | First input queue holds data |
| a_data | input | 16 | Head sample of the first queue, signed |
| a_pop | output | 1 | Pop strobe to the first queue |
| b_nempty | input | 1 | Second input queue holds data |
| b_data | input | 16 | Head sample of the second queue, signed |
| b_pop | output | 1 | Pop strobe to the second queue |
| cfg_shift | input | 4 | Rounding shift amount |
| cfg_clear | input | 1 | Request to zero the accumulator before the next operation |
| out_full | input | 1 | Output queue cannot accept data |
| out_push | output | 1 | Push strobe to the output queue |
| out_data | output | 16 | Rounded, saturated result, signed |

## Verification
The bound checker watches the handshakes in every cycle: pops only with data on both sides and always paired, no push into a full queue, a waiting result held stable, no pop once both stages are blocked, and every pop followed by an occupied first stage. Only the bench's scenarios can show the arithmetic. It compares the pushed values, including rounding ties and both saturation limits, against a reference that uses floor division. The scenarios also cover the exact two-cycle latency, the pending clear, the per-operation capture of settings, and the result ordering and count when a blocked output is released.

// File: rtl/mac_pkg.sv
package mac_pkg;
  // Default geometry shared by the stream unit and its checker
  localparam int unsigned SAMPLE_W_DEF = 16;
  localparam int unsigned ACCUM_W_DEF  = 40;
  localparam int unsigned SHIFT_W_DEF  = 4;

  // Occupancy of a pipeline slot
  typedef enum logic {
    SLOT_IDLE = 1'b0,
    SLOT_FULL = 1'b1
  } slot_e;
endpackage

// File: rtl/mac_issue.sv
module mac_issue (
  input  logic clk,
  input  logic rst_n,
  input  logic a_nempty,
  input  logic b_nempty,
  input  logic s1_ready,
  input  logic cfg_clear,
  output logic fire,
  output logic clr_take
);
  logic clr_pend;

  // An operation is accepted only with data on both sides and room in stage one
  assign fire     = rst_n & a_nempty & b_nempty & s1_ready;
  assign clr_take = cfg_clear | clr_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_pend <= 1'b0;
    end else if (fire) begin
      clr_pend <= 1'b0;
    end else if (cfg_clear) begin
      clr_pend <= 1'b1;
    end
  end
endmodule

// File: rtl/mac_mul_stage.sv
module mac_mul_stage #(
  parameter int unsigned SAMPLE_W = mac_pkg::SAMPLE_W_DEF,
  parameter int unsigned SHIFT_W  = mac_pkg::SHIFT_W_DEF,
  localparam int unsigned PROD_W  = 2 * SAMPLE_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       fire,
  input  logic signed [SAMPLE_W-1:0] a_data,
  input  logic signed [SAMPLE_W-1:0] b_data,
  input  logic [SHIFT_W-1:0]         shift_in,
  input  logic                       clr_in,
  input  logic                       s2_ready,
  output logic                       s1_ready,
  output logic                       s1_vld,
  output logic signed [PROD_W-1:0]   s1_prod,
  output logic [SHIFT_W-1:0]         s1_shift,
  output logic                       s1_clr
);
  mac_pkg::slot_e slot_q;

  function automatic logic signed [PROD_W-1:0] mul_full(
    input logic signed [SAMPLE_W-1:0] x,
    input logic signed [SAMPLE_W-1:0] y
  );
    logic signed [PROD_W-1:0] xe, ye;
    xe = PROD_W'(x);
    ye = PROD_W'(y);
    return xe * ye;
  endfunction

  assign s1_vld   = (slot_q == mac_pkg::SLOT_FULL);
  assign s1_ready = !s1_vld || s2_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q   <= mac_pkg::SLOT_IDLE;
      s1_prod  <= '0;
      s1_shift <= '0;
      s1_clr   <= 1'b0;
    end else if (s1_ready) begin
      slot_q <= fire ? mac_pkg::SLOT_FULL : mac_pkg::SLOT_IDLE;
      if (fire) begin
        s1_prod  <= mul_full(a_data, b_data);
        s1_shift <= shift_in;
        s1_clr   <= clr_in;
      end
    end
  end
endmodule

// File: rtl/mac_acc_stage.sv
module mac_acc_stage #(
  parameter int unsigned SAMPLE_W = mac_pkg::SAMPLE_W_DEF,
  parameter int unsigned ACCUM_W  = mac_pkg::ACCUM_W_DEF,
  parameter int unsigned SHIFT_W  = mac_pkg::SHIFT_W_DEF,
  localparam int unsigned PROD_W  = 2 * SAMPLE_W,
  localparam int unsigned WIDE_W  = ACCUM_W + 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       s1_vld,
  input  logic signed [PROD_W-1:0]   s1_prod,
  input  logic [SHIFT_W-1:0]         s1_shift,
  input  logic                       s1_clr,
  input  logic                       out_full,
  output logic                       s2_ready,
  output logic                       s2_vld,
  output logic signed [SAMPLE_W-1:0] s2_res
);
  localparam logic signed [WIDE_W-1:0] MAX_V = WIDE_W'((1 << (SAMPLE_W - 1)) - 1);
  localparam logic signed [WIDE_W-1:0] MIN_V = -WIDE_W'(1 << (SAMPLE_W - 1));

  logic signed [ACCUM_W-1:0] acc_q;
  logic signed [ACCUM_W-1:0] acc_next;
  logic                      move;
  mac_pkg::slot_e            slot_q;

  // Half-up rounding, arithmetic shift, then clamp to the sample range
  function automatic logic signed [SAMPLE_W-1:0] round_sat(
    input logic signed [ACCUM_W-1:0] v,
    input logic [SHIFT_W-1:0]        sh
  );
    logic signed [WIDE_W-1:0] bias, sum, shd;
    bias = '0;
    if (sh != '0) bias[sh - 1'b1] = 1'b1;
    sum = WIDE_W'(v) + bias;
    shd = sum >>> sh;
    if (shd > MAX_V)      return MAX_V[SAMPLE_W-1:0];
    else if (shd < MIN_V) return MIN_V[SAMPLE_W-1:0];
    else                  return shd[SAMPLE_W-1:0];
  endfunction

  assign s2_vld   = (slot_q == mac_pkg::SLOT_FULL);
  assign s2_ready = !s2_vld || !out_full;
  assign move     = s1_vld && s2_ready;
  assign acc_next = (s1_clr ? '0 : acc_q) + ACCUM_W'(s1_prod);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= mac_pkg::SLOT_IDLE;
      acc_q  <= '0;
      s2_res <= '0;
    end else if (move) begin
      slot_q <= mac_pkg::SLOT_FULL;
      acc_q  <= acc_next;
      s2_res <= round_sat(acc_next, s1_shift);
    end else if (s2_ready) begin
      slot_q <= mac_pkg::SLOT_IDLE;
    end
  end
endmodule

// File: rtl/mac_round_stream.sv
module mac_round_stream #(
  parameter int unsigned SAMPLE_W = mac_pkg::SAMPLE_W_DEF,
  parameter int unsigned ACCUM_W  = mac_pkg::ACCUM_W_DEF,
  parameter int unsigned SHIFT_W  = mac_pkg::SHIFT_W_DEF
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       a_nempty,
  input  logic signed [SAMPLE_W-1:0] a_data,
  output logic                       a_pop,
  input  logic                       b_nempty,
  input  logic signed [SAMPLE_W-1:0] b_data,
  output logic                       b_pop,
  input  logic [SHIFT_W-1:0]         cfg_shift,
  input  logic                       cfg_clear,
  input  logic                       out_full,
  output logic                       out_push,
  output logic signed [SAMPLE_W-1:0] out_data
);
  localparam int unsigned PROD_W = 2 * SAMPLE_W;

  // Named internal events, visible to the bound checker
  logic                     fire;
  logic                     clr_take;
  logic                     s1_ready;
  logic                     s1_vld;
  logic signed [PROD_W-1:0] s1_prod;
  logic [SHIFT_W-1:0]       s1_shift;
  logic                     s1_clr;
  logic                     s2_ready;
  logic                     s2_vld;

  mac_issue u_issue (
    .clk      (clk),
    .rst_n    (rst_n),
    .a_nempty (a_nempty),
    .b_nempty (b_nempty),
    .s1_ready (s1_ready),
    .cfg_clear(cfg_clear),
    .fire     (fire),
    .clr_take (clr_take)
  );

  mac_mul_stage #(.SAMPLE_W(SAMPLE_W), .SHIFT_W(SHIFT_W)) u_mul (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (fire),
    .a_data  (a_data),
    .b_data  (b_data),
    .shift_in(cfg_shift),
    .clr_in  (clr_take),
    .s2_ready(s2_ready),
    .s1_ready(s1_ready),
    .s1_vld  (s1_vld),
    .s1_prod (s1_prod),
    .s1_shift(s1_shift),
    .s1_clr  (s1_clr)
  );

  mac_acc_stage #(.SAMPLE_W(SAMPLE_W), .ACCUM_W(ACCUM_W), .SHIFT_W(SHIFT_W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .s1_vld  (s1_vld),
    .s1_prod (s1_prod),
    .s1_shift(s1_shift),
    .s1_clr  (s1_clr),
    .out_full(out_full),
    .s2_ready(s2_ready),
    .s2_vld  (s2_vld),
    .s2_res  (out_data)
  );

  assign a_pop    = fire;
  assign b_pop    = fire;
  assign out_push = s2_vld && !out_full;
endmodule

// File: rtl/mac_round_stream_chk.sv
module mac_round_stream_chk #(
  parameter int unsigned SAMPLE_W = mac_pkg::SAMPLE_W_DEF
) (
  input logic                clk,
  input logic                rst_n,
  input logic                a_nempty,
  input logic                b_nempty,
  input logic                a_pop,
  input logic                b_pop,
  input logic                out_full,
  input logic                out_push,
  input logic [SAMPLE_W-1:0] out_data,
  input logic                s1_vld,
  input logic                s2_vld
);
  // R1
  pop_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_pop |-> (a_nempty && b_nempty));

  // R1
  pop_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_pop == b_pop);

  // R5
  push_not_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_push |-> !out_full);

  // R5
  hold_while_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_vld && out_full) |=> (s2_vld && $stable(out_data)));

  // R6
  no_pop_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld && s2_vld && out_full) |-> !a_pop);

  // R7
  pop_fills_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_pop |=> s1_vld);
endmodule

bind mac_round_stream mac_round_stream_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .a_nempty(a_nempty),
  .b_nempty(b_nempty),
  .a_pop   (a_pop),
  .b_pop   (b_pop),
  .out_full(out_full),
  .out_push(out_push),
  .out_data(out_data),
  .s1_vld  (s1_vld),
  .s2_vld  (s2_vld)
);

// File: tb/mac_round_stream_tb.sv
module mac_round_stream_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic a_nempty, b_nempty, cfg_clear, out_full;
  logic signed [15:0] a_data, b_data;
  logic [3:0] cfg_shift;
  logic a_pop, b_pop, out_push;
  logic signed [15:0] out_data;

  always #2 clk = ~clk;

  mac_round_stream u_dut (
    .clk(clk), .rst_n(rst_n),
    .a_nempty(a_nempty), .a_data(a_data), .a_pop(a_pop),
    .b_nempty(b_nempty), .b_data(b_data), .b_pop(b_pop),
    .cfg_shift(cfg_shift), .cfg_clear(cfg_clear),
    .out_full(out_full), .out_push(out_push), .out_data(out_data)
  );

  // {clear, stall, shift[3:0], a[15:0], b[15:0]}
  localparam int NV = 10;
  localparam logic [37:0] VEC [NV] = '{
    {1'b1, 1'b0, 4'd0,  16'sd3,      16'sd4},
    {1'b0, 1'b0, 4'd0,  -16'sd5,     16'sd6},
    {1'b0, 1'b1, 4'd2,  16'sd100,    16'sd100},
    {1'b1, 1'b1, 4'd1,  16'sd7,      -16'sd9},
    {1'b0, 1'b0, 4'd0,  16'sd32767,  16'sd32767},
    {1'b1, 1'b0, 4'd0,  -16'sd32768, 16'sd32767},
    {1'b1, 1'b1, 4'd15, -16'sd32768, -16'sd32768},
    {1'b1, 1'b0, 4'd1,  -16'sd3,     16'sd1},
    {1'b0, 1'b1, 4'd2,  -16'sd1,     16'sd1},
    {1'b1, 1'b0, 4'd1,  16'sd5,      16'sd1}
  };

  int n_chk = 0, n_fail = 0, cyc = 0, n_pop = 0, n_push = 0;
  bit last_pop, last_push;
  logic signed [15:0] last_data;
  longint acc_m = 0;
  bit pend_m = 0;
  logic signed [15:0] expq [$];

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference rounding: floor((v + half) / 2^s) by integer division, then clamp
  function automatic longint ref_round(input longint v, input int s);
    longint t, d, q;
    d = longint'(1) <<< s;
    t = (s == 0) ? v : v + (d / 2);
    q = t / d;
    if ((t % d != 0) && (t < 0)) q = q - 1;
    if (q > 32767) q = 32767;
    if (q < -32768) q = -32768;
    return q;
  endfunction

  // Inputs change at the falling edge; sample 1 ns later, then step one cycle
  task automatic cycle();
    #1;
    last_pop  = a_pop;
    last_push = out_push;
    last_data = out_data;
    if (rst_n) begin
      if (a_pop) begin
        n_pop++;
        if (cfg_clear || pend_m) acc_m = 0;
        acc_m = acc_m + longint'(a_data) * longint'(b_data);
        expq.push_back(16'(ref_round(acc_m, int'(cfg_shift))));
        pend_m = 0;
      end else if (cfg_clear) begin
        pend_m = 1;
      end
      if (out_push) begin
        n_push++;
        if (expq.size() == 0) check(0, "R6 unexpected push", out_data, 0);
        else begin
          logic signed [15:0] e;
          e = expq.pop_front();
          check(out_data == e, "R2 R3 R4 R9 result", out_data, e);
        end
      end
    end
    @(negedge clk);
    cyc++;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; a_nempty = 1; b_nempty = 1; a_data = 16'sd9; b_data = 16'sd9;
    cfg_shift = 0; cfg_clear = 0; out_full = 0;
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      cycle();
      check(!last_pop && !last_push, "R10 reset quiet", {last_pop, last_push}, 0);
    end
    rst_n = 1; a_nempty = 0; b_nempty = 0;
    cycle();
    check(!last_push, "R10 no push after reset", last_push, 0);

    // R1: one side empty, no pop
    a_nempty = 1; b_nempty = 0;
    for (int i = 0; i < 3; i++) begin
      cycle();
      check(!last_pop, "R1 one queue empty", last_pop, 0);
    end
    a_nempty = 0; b_nempty = 1;
    cycle();
    check(!last_pop, "R1 other queue empty", last_pop, 0);

    // Vector walk with intermittent output stall
    for (int i = 0; i < NV; i++) begin
      int guard;
      cfg_clear = VEC[i][37]; cfg_shift = VEC[i][35:32];
      a_data = VEC[i][31:16]; b_data = VEC[i][15:0];
      a_nempty = 1; b_nempty = 1;
      guard = 0;
      do begin
        out_full = VEC[i][36] & cyc[0];
        cycle();
        guard++;
      end while (!last_pop && guard < 20);
      check(last_pop, "R6 vector accepted", last_pop, 1);
    end
    a_nempty = 0; b_nempty = 0; cfg_clear = 0; out_full = 0;
    for (int i = 0; i < 6; i++) cycle();

    // R7: exact latency
    a_data = 16'sd2; b_data = 16'sd3; cfg_shift = 0; cfg_clear = 1;
    a_nempty = 1; b_nempty = 1;
    cycle();
    check(last_pop, "R7 pop cycle", last_pop, 1);
    a_nempty = 0; b_nempty = 0; cfg_clear = 0;
    cycle();
    check(!last_push, "R7 no push at c+1", last_push, 0);
    cycle();
    check(last_push, "R7 push at c+2", last_push, 1);
    check(last_data == 16'sd6, "R7 latency value", last_data, 6);

    // R8: clear pulsed while idle stays pending
    cfg_clear = 1;
    cycle();
    cfg_clear = 0;
    cycle();

    // R5 and R6: blocked output, at most two operations in flight
    out_full = 1; a_data = 16'sd1; b_data = 16'sd1; cfg_shift = 0;
    a_nempty = 1; b_nempty = 1;
    begin
      int pops;
      logic signed [15:0] held;
      pops = 0;
      for (int i = 0; i < 6; i++) begin
        cycle();
        if (last_pop) pops++;
        check(!last_push, "R5 no push while full", last_push, 0);
        if (i == 2) held = last_data;
        if (i > 2) check(last_data == held, "R5 held data", last_data, held);
      end
      check(pops == 2, "R6 pops stop when blocked", pops, 2);
      a_nempty = 0; b_nempty = 0; out_full = 0;
      cycle();
      check(last_push && last_data == 16'sd1, "R8 pending clear result", last_data, 1);
      cycle();
      check(last_push && last_data == 16'sd2, "R6 second result in order", last_data, 2);
    end
    for (int i = 0; i < 4; i++) cycle();

    check(n_push == n_pop, "R6 push count equals pop count", n_push, n_pop);
    check(expq.size() == 0, "R6 nothing outstanding", expq.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule